// File: doc/BRIEF.md
# Mesh Router Input Port with Virtual Channels

This block is one input side of a five-direction mesh router that uses wormhole switching. It takes 10-bit flits from a neighbouring router or from the local processing element and places them in one of several virtual-channel queues. The flit's channel is chosen by the sender. Idle flits are dropped at the door. Each queue shows the upstream sender a per-channel full flag.

For each channel the port works out the outgoing direction with dimension-ordered routing: X is resolved first, then Y. The route is taken from the head flit of a packet and kept until the packet's tail has left. Every non-empty channel raises a request and shows its direction, so the switch fabric can decide where the flit may go. The fabric answers with a per-channel path grant. Among the channels that have both data and a grant, the port sends one flit per cycle and rotates between them. A packet that is stalled downstream therefore never holds up traffic on another channel.

Top module: `mesh_vc_input_port`

## Requirements
- R1: After reset, `out_valid`, every bit of `vc_full` and every bit of `vc_req` are 0.
- R2: A flit whose type is Idle (`in_type` = 2'b00) is never stored, and nothing is stored while `in_valid` is low. Neither case raises `vc_req` or produces output.
- R3: Each channel stores at most DEPTH (default 4) flits. `vc_full[v]` is 1 from the cycle after the DEPTH-th flit is stored until a flit leaves. A flit offered to a full channel is discarded.
- R4: Within one channel, flits leave in the order in which they were stored.
- R5: Type codes are Start=01, Body=10, End=11. On a Start flit, destination x is `data[3:2]` and y is `data[1:0]`. The direction codes are Local=0, North=1, East=2, South=3, West=4. The rules are applied in this order: dest x > own x gives East; dest x < own x gives West; dest y > own y gives South; dest y < own y gives North; otherwise Local. While a Start flit is at the head of channel v, `vc_req_dir[3v+2:3v]` shows that direction.
- R6: Body and End flits carry the direction taken from their packet's Start flit, whatever their data holds. Once the End flit has left, the next Start flit is routed afresh.
- R7: When `vc_req[v]` and `path_grant[v]` are both 1 at a clock edge and channel v is chosen, the head flit appears on `out_*` after that edge. It shows with `out_valid`=1, `out_vc`=v and its direction. With no chosen channel, `out_valid` is 0.
- R8: At most one flit leaves per cycle. When more than one channel is eligible, the channel that sent last is passed over in favour of another.
- R9: A channel without a grant does not stop another granted channel from sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_vc | input | VC_W | Channel of the incoming flit |
| in_type | input | 2 | Incoming flit type |
| in_data | input | 8 | Incoming flit data |
| vc_full | output | NUM_VC | Per-channel full flag toward the sender |
| path_grant | input | NUM_VC | Per-channel permission from the switch fabric |
| vc_req | output | NUM_VC | Channel holds a flit |
| vc_req_dir | output | 3*NUM_VC | Direction of each channel's head flit |
| out_valid | output | 1 | Flit presented to the fabric |
| out_vc | output | VC_W | Channel of the presented flit |
| out_type | output | 2 | Type of the presented flit |
| out_data | output | 8 | Data of the presented flit |
| out_dir | output | 3 | Direction of the presented flit |

## Verification
Several properties are checked on every cycle:
- Each queue's occupancy stays within bounds.
- A flit leaves only with both request and grant present.
- At most one channel is served per cycle.
- The output tracks the previous cycle's selection.
- A latched route stays fixed while its packet is still in flight.
- The rotation skips the last-served channel whenever a competitor is waiting.

The bench scenarios cover what per-cycle checks cannot show. They sweep every destination coordinate against the expected direction, and confirm that body data is ignored for routing and that the route is released after a tail. They also check ordering and dropping around a full queue, strict alternation under contention, and bypass of an ungranted channel.

// File: rtl/mip_pkg.sv
`timescale 1ns/1ps
package mip_pkg;
    localparam int FLIT_DATA_W = 8;
    localparam int COORD_W     = 2;
    localparam int DIR_W       = 3;

    typedef enum logic [1:0] {
        FT_IDLE  = 2'b00,
        FT_START = 2'b01,
        FT_BODY  = 2'b10,
        FT_END   = 2'b11
    } flit_type_e;

    typedef enum logic [DIR_W-1:0] {
        DIR_LOCAL = 3'd0,
        DIR_NORTH = 3'd1,
        DIR_EAST  = 3'd2,
        DIR_SOUTH = 3'd3,
        DIR_WEST  = 3'd4
    } dir_e;

    typedef struct packed {
        flit_type_e             ftype;
        logic [FLIT_DATA_W-1:0] data;
    } flit_t;

    // X dimension resolved before Y
    function automatic dir_e xy_next_hop(input logic [COORD_W-1:0] dst_x,
                                         input logic [COORD_W-1:0] dst_y,
                                         input logic [COORD_W-1:0] own_x,
                                         input logic [COORD_W-1:0] own_y);
        if (dst_x > own_x)      return DIR_EAST;
        else if (dst_x < own_x) return DIR_WEST;
        else if (dst_y > own_y) return DIR_SOUTH;
        else if (dst_y < own_y) return DIR_NORTH;
        else                    return DIR_LOCAL;
    endfunction
endpackage

// File: rtl/mip_vc_fifo.sv
`timescale 1ns/1ps
module mip_vc_fifo
    import mip_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  flit_t wr_flit,
    input  logic  rd_en,
    output flit_t head,
    output logic  empty,
    output logic  full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        flit_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic [CNT_W-1:0]  cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_wr, do_rd;

    always_comb begin
        st_d  = st_q;
        do_wr = wr_en && (st_q.cnt != CNT_W'(DEPTH));
        do_rd = rd_en && (st_q.cnt != '0);
        if (do_wr) begin
            st_d.mem[st_q.wptr] = wr_flit;
            st_d.wptr = (st_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_rd) begin
            st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rptr];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R3
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full); // R3
endmodule

// File: rtl/mip_route_unit.sv
`timescale 1ns/1ps
module mip_route_unit
    import mip_pkg::*;
#(
    parameter int OWN_X = 1,
    parameter int OWN_Y = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  flit_type_e             head_type,
    input  logic [2*COORD_W-1:0]   head_dest,
    input  logic                   pop,
    output dir_e                   head_dir
);
    typedef struct packed {
        logic held;
        dir_e route;
    } route_st_t;

    route_st_t st_d, st_q;
    dir_e      calc_dir;

    always_comb begin
        calc_dir = xy_next_hop(head_dest[2*COORD_W-1:COORD_W], head_dest[COORD_W-1:0],
                               COORD_W'(OWN_X), COORD_W'(OWN_Y));
        head_dir = (head_type == FT_START || !st_q.held) ? calc_dir : st_q.route;
        st_d = st_q;
        if (pop) begin
            if (head_type == FT_START) begin
                st_d.held  = 1'b1;
                st_d.route = calc_dir;
            end else if (head_type == FT_END) begin
                st_d.held  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !(pop && (head_type == FT_END || head_type == FT_START)))
        |=> (st_q.held && $stable(st_q.route))); // R6
endmodule

// File: rtl/mip_rr_arb.sv
`timescale 1ns/1ps
module mip_rr_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    found;
    int      cand;

    always_comb begin
        st_d  = st_q;
        gnt   = '0;
        found = 1'b0;
        cand  = 0;
        for (int i = 1; i <= N; i++) begin
            cand = (int'(st_q.last) + i) % N;
            if (!found && req[cand]) begin
                gnt[cand]    = 1'b1;
                found        = 1'b1;
                st_d.last    = IDX_W'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.last <= IDX_W'(N - 1);
        else        st_q <= st_d;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R8
    AST_ROTATE_FAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(gnt)) && (|(req & ~$past(gnt)))) |-> ((gnt & $past(gnt)) == '0)); // R8
endmodule

// File: rtl/mesh_vc_input_port.sv
`timescale 1ns/1ps
module mesh_vc_input_port
    import mip_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int DEPTH  = 4,
    parameter int OWN_X  = 1,
    parameter int OWN_Y  = 1,
    localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [VC_W-1:0]         in_vc,
    input  logic [1:0]              in_type,
    input  logic [FLIT_DATA_W-1:0]  in_data,
    output logic [NUM_VC-1:0]       vc_full,
    input  logic [NUM_VC-1:0]       path_grant,
    output logic [NUM_VC-1:0]       vc_req,
    output logic [NUM_VC*DIR_W-1:0] vc_req_dir,
    output logic                    out_valid,
    output logic [VC_W-1:0]         out_vc,
    output logic [1:0]              out_type,
    output logic [FLIT_DATA_W-1:0]  out_data,
    output logic [DIR_W-1:0]        out_dir
);
    typedef struct packed {
        logic            valid;
        logic [VC_W-1:0] vc;
        flit_t           flit;
        dir_e            dir;
    } out_st_t;

    flit_t               in_flit;
    flit_t               head [NUM_VC];
    dir_e                hdir [NUM_VC];
    logic [NUM_VC-1:0]   empty, full, wr_en, pop;
    out_st_t             out_d, out_q;

    assign in_flit.ftype = flit_type_e'(in_type);
    assign in_flit.data  = in_data;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        assign wr_en[v] = in_valid && (in_vc == VC_W'(v)) && (in_flit.ftype != FT_IDLE);

        mip_vc_fifo #(.DEPTH(DEPTH)) i_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[v]),
            .wr_flit (in_flit),
            .rd_en   (pop[v]),
            .head    (head[v]),
            .empty   (empty[v]),
            .full    (full[v])
        );

        mip_route_unit #(.OWN_X(OWN_X), .OWN_Y(OWN_Y)) i_route (
            .clk       (clk),
            .rst_n     (rst_n),
            .head_type (head[v].ftype),
            .head_dest (head[v].data[2*COORD_W-1:0]),
            .pop       (pop[v]),
            .head_dir  (hdir[v])
        );

        assign vc_req[v]                  = !empty[v];
        assign vc_full[v]                 = full[v];
        assign vc_req_dir[v*DIR_W +: DIR_W] = hdir[v];
    end

    mip_rr_arb #(.N(NUM_VC)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (vc_req & path_grant),
        .gnt   (pop)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = |pop;
        for (int v = 0; v < NUM_VC; v++) begin
            if (pop[v]) begin
                out_d.vc   = VC_W'(v);
                out_d.flit = head[v];
                out_d.dir  = hdir[v];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_vc    = out_q.vc;
    assign out_type  = out_q.flit.ftype;
    assign out_data  = out_q.flit.data;
    assign out_dir   = out_q.dir;

    AST_POP_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop & ~(path_grant & vc_req)) == '0); // R7
    AST_OUT_TRACKS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(|pop)); // R7
endmodule

// File: tb/test_mesh_vc_input_port.sv
`timescale 1ns/1ps
module test_mesh_vc_input_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [0:0] in_vc = '0;
    logic [1:0] in_type = 2'b00;
    logic [7:0] in_data = '0;
    logic [1:0] vc_full;
    logic [1:0] path_grant = '0;
    logic [1:0] vc_req;
    logic [5:0] vc_req_dir;
    logic       out_valid;
    logic [0:0] out_vc;
    logic [1:0] out_type;
    logic [7:0] out_data;
    logic [2:0] out_dir;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    mesh_vc_input_port #(.NUM_VC(2), .DEPTH(4), .OWN_X(1), .OWN_Y(1)) i_mesh_vc_input_port (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_type(in_type),
        .in_data(in_data), .vc_full(vc_full), .path_grant(path_grant), .vc_req(vc_req),
        .vc_req_dir(vc_req_dir), .out_valid(out_valid), .out_vc(out_vc), .out_type(out_type),
        .out_data(out_data), .out_dir(out_dir)
    );

    localparam logic [1:0] T_IDLE = 2'b00, T_START = 2'b01, T_BODY = 2'b10, T_END = 2'b11;

    function automatic int exp_dir(input int dx, input int dy);
        if (dx > 1) return 2;
        if (dx < 1) return 4;
        if (dy > 1) return 3;
        if (dy < 1) return 1;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int vc, input logic [1:0] t, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_vc = vc[0]; in_type = t; in_data = d;
        @(negedge clk);
        in_valid = 1'b0; in_type = T_IDLE;
    endtask

    task automatic pop_check(input int vc, input logic [1:0] t, input logic [7:0] d,
                             input int dir, input string tag);
        @(negedge clk);
        path_grant = 2'b01 << vc;
        @(posedge clk);
        #1;
        path_grant = '0;
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " vc"}, int'(out_vc), vc);
        chk({tag, " type"}, int'(out_type), int'(t));
        chk({tag, " data"}, int'(out_data), int'(d));
        chk({tag, " dir"}, int'(out_dir), dir);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin : main
        logic [7:0] q0 [3];
        logic [7:0] q1 [3];
        int prev_vc;
        int i0, i1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 vc_full", int'(vc_full), 0);
        chk("R1 vc_req", int'(vc_req), 0);

        // R5 sweep over all destination coordinates, R6 tail follows head
        for (int dx = 0; dx < 4; dx++) begin
            for (int dy = 0; dy < 4; dy++) begin
                push(0, T_START, 8'((dx << 2) | dy));
                #1;
                chk("R5 req_dir", int'(vc_req_dir[2:0]), exp_dir(dx, dy));
                pop_check(0, T_START, 8'((dx << 2) | dy), exp_dir(dx, dy), "R5 start");
                push(0, T_END, 8'hA5);
                pop_check(0, T_END, 8'hA5, exp_dir(dx, dy), "R6 end");
            end
        end

        // R6 body data does not reroute; route released after End
        push(0, T_START, 8'h0D);   // x=3 -> East
        push(0, T_BODY, 8'h01);    // would be West if routed
        push(0, T_END, 8'h00);
        pop_check(0, T_START, 8'h0D, 2, "R6 hold start");
        #1;
        chk("R6 body req_dir", int'(vc_req_dir[2:0]), 2);
        pop_check(0, T_BODY, 8'h01, 2, "R6 hold body");
        pop_check(0, T_END, 8'h00, 2, "R6 hold end");
        push(0, T_START, 8'h05);   // x=1,y=1 -> Local
        #1;
        chk("R6 fresh route", int'(vc_req_dir[2:0]), 0);
        pop_check(0, T_START, 8'h05, 0, "R6 fresh start");
        push(0, T_END, 8'h06);
        pop_check(0, T_END, 8'h06, 0, "R6 fresh end");

        // R3 / R4 fill channel 1 past capacity
        push(1, T_START, 8'h05);
        push(1, T_BODY, 8'h11);
        push(1, T_BODY, 8'h12);
        chk("R3 not yet full", int'(vc_full[1]), 0);
        push(1, T_END, 8'h13);
        chk("R3 full", int'(vc_full), 2);
        push(1, T_START, 8'h20);   // dropped
        chk("R3 still full", int'(vc_full[1]), 1);
        pop_check(1, T_START, 8'h05, 0, "R4 order 0");
        chk("R3 full cleared", int'(vc_full[1]), 0);
        pop_check(1, T_BODY, 8'h11, 0, "R4 order 1");
        pop_check(1, T_BODY, 8'h12, 0, "R4 order 2");
        pop_check(1, T_END, 8'h13, 0, "R4 order 3");
        chk("R3 overflow dropped", int'(vc_req), 0);

        // R2 idle and invalid flits not stored
        @(negedge clk);
        in_valid = 1'b1; in_vc = 1'b0; in_type = T_IDLE; in_data = 8'hFF;
        @(negedge clk);
        in_vc = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_type = T_START; in_data = 8'h05;
        @(negedge clk);
        in_type = T_IDLE;
        chk("R2 no request", int'(vc_req), 0);
        path_grant = 2'b11;
        @(posedge clk);
        #1;
        path_grant = '0;
        chk("R2 no output", int'(out_valid), 0);

        // R8 alternation under contention
        q0[0] = 8'h05; q0[1] = 8'h31; q0[2] = 8'h32;
        q1[0] = 8'h05; q1[1] = 8'h41; q1[2] = 8'h42;
        push(0, T_START, q0[0]); push(0, T_BODY, q0[1]); push(0, T_END, q0[2]);
        push(1, T_START, q1[0]); push(1, T_BODY, q1[1]); push(1, T_END, q1[2]);
        @(negedge clk);
        path_grant = 2'b11;
        prev_vc = -1; i0 = 0; i1 = 0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk);
            #1;
            chk("R8 valid", int'(out_valid), 1);
            if (k > 0) chk("R8 alternates", int'(int'(out_vc) != prev_vc), 1);
            prev_vc = int'(out_vc);
            if (out_vc == 1'b0) begin
                if (i0 < 3) chk("R8 vc0 data", int'(out_data), int'(q0[i0]));
                i0++;
            end else begin
                if (i1 < 3) chk("R8 vc1 data", int'(out_data), int'(q1[i1]));
                i1++;
            end
        end
        path_grant = '0;
        chk("R8 both drained", int'(vc_req), 0);

        // R9 ungranted channel bypassed
        push(0, T_START, 8'h0D); push(0, T_BODY, 8'h51); push(0, T_END, 8'h52);
        push(1, T_START, 8'h01); push(1, T_BODY, 8'h61); push(1, T_END, 8'h62);
        @(negedge clk);
        path_grant = 2'b10;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            chk("R9 bypass valid", int'(out_valid), 1);
            chk("R9 bypass vc", int'(out_vc), 1);
            chk("R9 bypass dir", int'(out_dir), 4);
        end
        path_grant = '0;
        chk("R9 blocked waits", int'(vc_req), 1);
        pop_check(0, T_START, 8'h0D, 2, "R9 late start");
        pop_check(0, T_BODY, 8'h51, 2, "R9 late body");
        pop_check(0, T_END, 8'h52, 2, "R9 late end");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule